// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the serial front end of a small non-volatile memory. While a write instruction is in progress it gathers data bytes into a one-page staging buffer of 64 bytes. The first address picks the page and a starting offset. Each byte advances only the 6-bit offset, which wraps from 63 back to 0, so a later byte lands on top of an earlier one at the same offset. A 64-bit mask records which offsets were received and allowed by the protection logic.

When chip select rises cleanly on a byte boundary, after at least one whole data byte, the block raises busy for a fixed number of system-clock cycles. In the first 64 cycles of that window it scans the buffer in ascending offset order and drives one array write for each offset that is both received and permitted. Offsets that received nothing are never written, so they keep their old contents. When the window ends, a single-cycle pulse tells the status logic to clear its write-enable latch. If bytes arrived but none of them was permitted, the pulse is given at once and no busy window starts. A frame that ends off a byte boundary, or with no data byte, changes nothing.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, busy_o, mem_we_o and wen_clr_o are 0.
- R2: wr_start_i loads the address. Each accepted data byte adds 1 to the low 6 bits of cur_addr_o, wrapping from 63 to 0, and leaves the upper ADDR_W-6 bits unchanged. Every write in the following commit uses those same upper bits in mem_addr_o.
- R3: When more than one byte lands on the same offset, the commit writes only the last of them. After more than 64 bytes, exactly 64 writes are made, each carrying the last byte received for its offset.
- R4: The commit writes only the offsets that received a byte since the last wr_start_i. Every other offset gets no write strobe.
- R5: A byte that arrives with permit_i = 0 is not written. Its offset gets no write strobe.
- R6: A commit starts only on a frame_end_i pulse with aligned_i = 1, after a wr_start_i and at least one data byte. If aligned_i = 0, or no byte was received, busy_o and wen_clr_o stay 0 and no write occurs.
- R7: busy_o rises in the cycle after the qualifying frame_end_i and stays high for exactly CYCLE_LEN cycles. mem_we_o is asserted only while busy, at most once per offset, in ascending offset order.
- R8: wen_clr_o is a one-cycle pulse in the cycle after the last busy cycle. Exactly one pulse is given per commit.
- R9: If bytes were received but none was permitted, wen_clr_o pulses in the cycle after frame_end_i, busy_o stays 0 and no write occurs.
- R10: While busy_o is 1, wr_start_i, data_stb_i and frame_end_i are ignored. They do not change cur_addr_o, the writes of the commit in progress, or the state that decides whether a later frame_end_i commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_start_i | input | 1 | Write instruction and address accepted (pulse) |
| wr_addr_i | input | ADDR_W | Start address of the write |
| data_stb_i | input | 1 | One complete data byte is on data_i (pulse) |
| data_i | input | 8 | Data byte |
| permit_i | input | 1 | Protection allows writing to cur_addr_o |
| frame_end_i | input | 1 | Chip select rose (pulse) |
| aligned_i | input | 1 | The frame ended on a byte boundary; qualifies frame_end_i |
| cur_addr_o | output | ADDR_W | Address of the next data byte, for the protection check |
| busy_o | output | 1 | Commit window in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | 8 | Array write data |
| wen_clr_o | output | 1 | Clear the write-enable latch (pulse) |

## Verification
Two events can fall in the same cycle: the array scan of a running commit, and the arrival of a new instruction with its start, bytes and frame end. The bench sends a complete frame to a different page while a commit is busy. It then checks that the writes of the running commit still carry the original page and data. It also checks that cur_addr_o did not move, and that a later aligned frame end with no new start commits nothing. A second overlap is the wrap at offset 63, where a new byte replaces the earlier byte at the same offset in the buffer. The bench judges this by the data that reaches the write port.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  localparam int unsigned PAGE_AW    = 6;
  localparam int unsigned PAGE_BYTES = 1 << PAGE_AW;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/wcb_page_buf.sv
module wcb_page_buf
  import wcb_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               take_i,
  input  byte_t              data_i,
  input  logic               permit_i,
  input  logic [PAGE_AW-1:0] rd_idx_i,
  output logic [ADDR_W-1:0]  cur_addr_o,
  output logic [ADDR_W-PAGE_AW-1:0] base_o,
  output byte_t              rd_data_o,
  output logic               rd_ok_o,
  output logic               any_ok_o,
  output logic               got_byte_o
);
  localparam int unsigned BASE_W = ADDR_W - PAGE_AW;

  byte_t                  buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]  ok_q;
  logic [PAGE_AW-1:0]     ptr_q;
  logic [BASE_W-1:0]      base_q;
  logic                   got_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q   <= '0;
      ptr_q  <= '0;
      base_q <= '0;
      got_q  <= 1'b0;
    end else if (start_i) begin
      ok_q   <= '0;
      ptr_q  <= addr_i[PAGE_AW-1:0];
      base_q <= addr_i[ADDR_W-1:PAGE_AW];
      got_q  <= 1'b0;
    end else if (take_i) begin
      ok_q[ptr_q] <= permit_i;
      ptr_q       <= ptr_q + 1'b1;
      got_q       <= 1'b1;
    end
  end

  // data storage needs no reset: the mask qualifies every entry
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_cell
    always_ff @(posedge clk_i) begin
      if (take_i && !start_i && ptr_q == PAGE_AW'(g)) buf_q[g] <= data_i;
    end
  end

  assign cur_addr_o = {base_q, ptr_q};
  assign base_o     = base_q;
  assign rd_data_o  = buf_q[rd_idx_i];
  assign rd_ok_o    = ok_q[rd_idx_i];
  assign any_ok_o   = |ok_q;
  assign got_byte_o = got_q;

  assert_base_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(base_q));
  assert_offset_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !start_i && ptr_q == '1) |=> (ptr_q == '0));
endmodule

// File: rtl/wcb_cycle_timer.sv
module wcb_cycle_timer #(
  parameter int unsigned CYCLE_LEN = 1000000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         launch_i,
  output logic                         busy_o,
  output logic [$clog2(CYCLE_LEN)-1:0] cnt_o,
  output logic                         fin_o
);
  localparam int unsigned CNT_W = $clog2(CYCLE_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_LEN - 1);

  logic             busy_q, fin_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
        cnt_q <= cnt_q + 1'b1;
      end else if (launch_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign fin_o  = fin_q;

  assert_window_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(cnt_q) == LAST));
  assert_fin_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |=> !fin_q);
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine
  import wcb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned CYCLE_LEN = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              data_stb_i,
  input  logic [7:0]        data_i,
  input  logic              permit_i,
  input  logic              frame_end_i,
  input  logic              aligned_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              wen_clr_o
);
  localparam int unsigned CNT_W  = $clog2(CYCLE_LEN);
  localparam int unsigned BASE_W = ADDR_W - PAGE_AW;

  logic               busy, fin, armed_q, skip_q;
  logic               start_ok, take_ok, end_ok, commit_req;
  logic               rd_ok, any_ok, got_byte, scan;
  logic [CNT_W-1:0]   cnt;
  logic [PAGE_AW-1:0] rd_idx;
  logic [BASE_W-1:0]  base;
  byte_t              rd_data;

  assign start_ok   = wr_start_i && !busy;
  assign take_ok    = data_stb_i && !busy;
  assign end_ok     = frame_end_i && !busy;
  assign commit_req = end_ok && aligned_i && armed_q && got_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      if (start_ok)    armed_q <= 1'b1;
      else if (end_ok) armed_q <= 1'b0;
      skip_q <= commit_req && !any_ok;
    end
  end

  wcb_page_buf #(.ADDR_W(ADDR_W)) u_buf (
    .clk_i, .rst_ni,
    .start_i   (start_ok),
    .addr_i    (wr_addr_i),
    .take_i    (take_ok),
    .data_i    (data_i),
    .permit_i  (permit_i),
    .rd_idx_i  (rd_idx),
    .cur_addr_o(cur_addr_o),
    .base_o    (base),
    .rd_data_o (rd_data),
    .rd_ok_o   (rd_ok),
    .any_ok_o  (any_ok),
    .got_byte_o(got_byte)
  );

  wcb_cycle_timer #(.CYCLE_LEN(CYCLE_LEN)) u_tmr (
    .clk_i, .rst_ni,
    .launch_i(commit_req && any_ok),
    .busy_o  (busy),
    .cnt_o   (cnt),
    .fin_o   (fin)
  );

  assign rd_idx     = cnt[PAGE_AW-1:0];
  assign scan       = busy && (cnt < CNT_W'(PAGE_BYTES));
  assign mem_we_o   = scan && rd_ok;
  assign mem_addr_o = {base, rd_idx};
  assign mem_data_o = rd_data;
  assign busy_o     = busy;
  assign wen_clr_o  = fin || skip_q;

  assert_we_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  assert_launch_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(frame_end_i && aligned_i));
  assert_clr_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_clr_o |-> !busy_o);
  assert_ignore_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cur_addr_o));
  assert_skip_no_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_q |-> !busy_o);
endmodule

// File: tb/page_commit_engine_tb_top.sv
`timescale 1ns/1ps
module page_commit_engine_tb_top;
  localparam int AW = 15;
  localparam int CL = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_start = 0, data_stb = 0, permit = 0, frame_end = 0, aligned = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] data = '0;
  logic [AW-1:0] cur_addr, mem_addr;
  logic busy, mem_we, wen_clr;
  logic [7:0] mem_data;

  always #2.5 clk = ~clk;

  page_commit_engine #(.ADDR_W(AW), .CYCLE_LEN(CL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_start_i(wr_start), .wr_addr_i(wr_addr),
    .data_stb_i(data_stb), .data_i(data), .permit_i(permit),
    .frame_end_i(frame_end), .aligned_i(aligned), .cur_addr_o(cur_addr),
    .busy_o(busy), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_data_o(mem_data), .wen_clr_o(wen_clr));

  int checks = 0, errors = 0;
  // monitor state
  logic [7:0] got_d [64];
  logic [63:0] got_v;
  int got_n, busy_n, clr_n, base_err, order_err, dup_err, last_off;
  logic [AW-7:0] exp_base;
  // model
  logic [7:0] exp_d [64];
  logic [63:0] exp_v;
  int off;

  always @(posedge clk) begin
    if (rst_n) begin
      if (busy) busy_n++;
      if (wen_clr) clr_n++;
      if (mem_we) begin
        if (mem_addr[AW-1:6] != exp_base) base_err++;
        if (int'(mem_addr[5:0]) <= last_off) order_err++;
        if (got_v[mem_addr[5:0]]) dup_err++;
        last_off = int'(mem_addr[5:0]);
        got_v[mem_addr[5:0]] = 1'b1;
        got_d[mem_addr[5:0]] = mem_data;
        got_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    got_v = '0; got_n = 0; busy_n = 0; clr_n = 0;
    base_err = 0; order_err = 0; dup_err = 0; last_off = -1;
    exp_v = '0;
  endtask

  task automatic do_start(input logic [AW-1:0] a);
    @(negedge clk); wr_start = 1; wr_addr = a;
    @(negedge clk); wr_start = 0;
    exp_base = a[AW-1:6]; off = int'(a[5:0]); exp_v = '0;
  endtask

  task automatic do_byte(input logic [7:0] b, input bit p, input bit model);
    @(negedge clk); data_stb = 1; data = b; permit = p;
    if (model) begin
      exp_v[off] = p; exp_d[off] = b; off = (off + 1) % 64;
    end
    @(negedge clk); data_stb = 0; permit = 0;
  endtask

  task automatic do_end(input bit al);
    @(negedge clk); frame_end = 1; aligned = al;
    @(negedge clk); frame_end = 0; aligned = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic judge_page(input string tag);
    int bad = 0;
    for (int i = 0; i < 64; i++) begin
      if (got_v[i] != exp_v[i]) bad++;
      else if (exp_v[i] && got_d[i] != exp_d[i]) bad++;
    end
    chk(bad == 0, tag, bad, 0);
    chk(got_n == $countones(exp_v), {tag, " count"}, got_n, $countones(exp_v));
    chk(base_err == 0 && order_err == 0 && dup_err == 0, "R7/R2 addr order",
        base_err + order_err + dup_err, 0);
  endtask

  task automatic t_reset();
    idle(1);
    chk(busy == 0 && mem_we == 0 && wen_clr == 0, "R1 reset outputs",
        {busy, mem_we, wen_clr}, 0);
  endtask

  task automatic t_wrap_partial();
    clear_mon();
    do_start(15'h1234);
    for (int i = 0; i < 12; i++) do_byte(8'hA0 + 8'(i), 1, 1);
    chk(cur_addr == 15'h1200, "R2 offset wrap", cur_addr, 15'h1200);
    for (int i = 12; i < 20; i++) do_byte(8'hA0 + 8'(i), 1, 1);
    @(negedge clk); frame_end = 1; aligned = 1;
    @(negedge clk); frame_end = 0; aligned = 0;
    chk(busy == 1, "R7 busy next cycle", busy, 1);
    idle(CL + 5);
    judge_page("R4 partial page");
    chk(busy_n == CL, "R7 busy length", busy_n, CL);
    chk(clr_n == 1, "R8 one clear pulse", clr_n, 1);
  endtask

  task automatic t_overrun();
    clear_mon();
    do_start(15'h0105);
    for (int i = 0; i < 70; i++) do_byte(8'(i * 3 + 1), 1, 1);
    do_end(1);
    idle(CL + 5);
    judge_page("R3 last bytes kept");
    chk(got_n == 64, "R3 64 writes", got_n, 64);
  endtask

  task automatic t_permit();
    clear_mon();
    do_start(15'h7FC0);
    for (int i = 0; i < 10; i++) do_byte(8'h50 + 8'(i), (i % 2) == 0, 1);
    do_end(1);
    idle(CL + 5);
    judge_page("R5 unpermitted skipped");
  endtask

  task automatic t_none_permitted();
    clear_mon();
    do_start(15'h0040);
    for (int i = 0; i < 4; i++) do_byte(8'h11, 0, 1);
    @(negedge clk); frame_end = 1; aligned = 1;
    @(negedge clk); frame_end = 0; aligned = 0;
    chk(wen_clr == 1 && busy == 0, "R9 immediate clear", {wen_clr, busy}, 2'b10);
    idle(10);
    chk(busy_n == 0 && got_n == 0 && clr_n == 1, "R9 no busy no write",
        busy_n * 256 + got_n * 16 + clr_n, 1);
  endtask

  task automatic t_misaligned();
    clear_mon();
    do_start(15'h0300);
    do_byte(8'h22, 1, 1);
    do_end(0);
    idle(CL + 5);
    chk(busy_n == 0 && got_n == 0 && clr_n == 0, "R6 misaligned ignored",
        busy_n + got_n + clr_n, 0);
    clear_mon();
    do_start(15'h0300);
    do_end(1);
    idle(CL + 5);
    chk(busy_n == 0 && got_n == 0 && clr_n == 0, "R6 no byte no commit",
        busy_n + got_n + clr_n, 0);
  endtask

  task automatic t_busy_ignore();
    logic [AW-1:0] held;
    clear_mon();
    do_start(15'h2A10);
    for (int i = 0; i < 3; i++) do_byte(8'hC0 + 8'(i), 1, 1);
    do_end(1);
    held = cur_addr;
    // new frame while busy: must be dropped
    @(negedge clk); wr_start = 1; wr_addr = 15'h0555;
    @(negedge clk); wr_start = 0;
    for (int i = 0; i < 5; i++) do_byte(8'hEE, 1, 0);
    chk(cur_addr == held, "R10 cur_addr held", cur_addr, held);
    do_end(1);
    idle(CL + 5);
    judge_page("R10 running commit intact");
    chk(clr_n == 1 && busy_n == CL, "R10 single commit", clr_n, 1);
    clear_mon();
    do_end(1);
    idle(CL + 5);
    chk(busy_n == 0 && got_n == 0 && clr_n == 0, "R10 start dropped",
        busy_n + got_n + clr_n, 0);
  endtask

  initial begin
    clear_mon();
    exp_base = '0; off = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_wrap_partial();
    t_overrun();
    t_permit();
    t_none_permitted();
    t_misaligned();
    t_busy_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule